// File: doc/BRIEF.md
# Area-Decoded External Bus Controller

This block sits between an on-chip requester and an external memory bus. It splits the external address space into eight equal areas and runs each access with the timing and data width set for the area that the address falls into. A request gives a word address, byte enables, a read/write flag and write data. The block drives the external address, the write data lanes, separate read and per-lane write strobes, and one active-low select line per area.

Each area has its own settings. It can use an 8-bit or a 16-bit data path. Its basic access takes either two clock states or three. A three-state access can add 0 to 3 programmed wait states. The area can also honour an external wait input. A global map select picks the area size. In the small map each area is 128 kB of a 1 MB space, so the area number is taken from address bits 19:17. In the large map each area is 2 MB of a 16 MB space, and the area number comes from bits 23:21. A 16-bit request to an 8-bit area runs as two byte cycles on the bus, and the requester sees one acknowledge only.

Top module: `area_bus_ctrl`

## Requirements
- R1: With `wide_map` low, the area index is address bits 19:17 and `ext_addr` bits 23:20 are driven to zero.
- R2: With `wide_map` high, the area index is address bits 23:21 and `ext_addr` carries the full request address.
- R3: At most one `ext_cs_n` bit is low. It is the bit of the accessed area, held low from the first state to the last state of a bus cycle and across both halves of a split access. All bits are high after reset and while idle.
- R4: An 8-bit area moves data on lanes 15:8 only and never pulls `ext_wrl_n` low. A lower-byte request (`req_be`=01) goes to the odd address with `req_wdata[7:0]` on `ext_dout[15:8]`, and a read returns that byte in `req_rdata[7:0]`. An upper-byte request (`req_be`=10) goes to the even address, and a read returns the byte in `req_rdata[15:8]` with zeros in bits 7:0.
- R5: A word request (`req_be`=11) to an 8-bit area runs two byte cycles, the even address with the upper byte first and then the odd address with the lower byte. Reads assemble to {even byte, odd byte}. The acknowledge comes only after the second cycle.
- R6: A 16-bit area runs one cycle. `ext_wrh_n` drives lane 15:8 and `ext_wrl_n` drives lane 7:0, and each follows `req_be[1]` and `req_be[0]`. `ext_addr[0]` is 1 only for a lower-byte-only request. Read and write strobes are never low together.
- R7: A two-state area holds a strobe low for 1 cycle. The acknowledge comes 3 cycles after the request is taken. Programmed waits and the wait pin have no effect on a two-state area.
- R8: A three-state area with N programmed waits holds the strobe low for 2+N cycles, and the acknowledge comes 4+N cycles after the request is taken.
- R9: When the area's pin-wait enable is set, each rising clock edge that ends the last non-final state with `ext_wait_n` low adds one more wait state. When the enable is clear, `ext_wait_n` is ignored.
- R10: `req_ack` is a one-cycle pulse in a cycle where every select is high. A read's data is on `req_rdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_map | input | 1 | 1: 2 MB areas in 16 MB; 0: 128 kB areas in 1 MB |
| area_bus16 | input | 8 | Per area: 1 = 16-bit data path, 0 = 8-bit |
| area_slow | input | 8 | Per area: 1 = three-state access, 0 = two-state |
| area_waits | input | 16 | Per area, 2 bits at [2k+1:2k]: programmed wait count |
| area_pin_wait | input | 8 | Per area: 1 = honour `ext_wait_n` |
| req_valid | input | 1 | Request present; held with its fields until `req_ack` |
| req_waddr | input | 23 | Request word address (bits 23:1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables: 11 word, 10 upper (even), 01 lower (odd) |
| req_wdata | input | 16 | Write data, bits 15:8 = even byte |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with `req_ack` |
| ext_addr | output | 24 | External byte address |
| ext_dout | output | 16 | External write data |
| ext_dout_en | output | 1 | High while a write cycle drives the data bus |
| ext_din | input | 16 | External read data |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wrh_n | output | 1 | Write strobe for lane 15:8, active low |
| ext_wrl_n | output | 1 | Write strobe for lane 7:0, active low |
| ext_wait_n | input | 1 | External wait request, active low |
| ext_cs_n | output | 8 | Per-area select, active low |

## Verification
The bench first checks area decoding. It uses an address whose upper bits would select a different area in the other map, so a decoder that reads the wrong bit field lights the wrong select. Split word accesses to 8-bit areas are checked for byte order, for the address of each half and for one acknowledge only. A swapped order or a missing second cycle shows up as wrong read data or an early acknowledge. Wait handling is probed three ways: the wait pin held low on a two-state area, held low on a three-state area with the pin disabled, and released on a chosen cycle on an enabled area. A design that counts waits wrongly, or samples the pin in the wrong state, acknowledges in a different cycle. Byte-lane tests catch strobes or data put on the wrong lane.

// File: rtl/area_bus_ctrl.sv
module area_bus_ctrl #(
  parameter int ADDR_W       = 24,
  parameter int NARROW_MAP_W = 20,
  parameter int WAIT_W       = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wide_map,
  input  logic [7:0]               area_bus16,
  input  logic [7:0]               area_slow,
  input  logic [8*WAIT_W-1:0]      area_waits,
  input  logic [7:0]               area_pin_wait,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:1]        req_waddr,
  input  logic                     req_write,
  input  logic [1:0]               req_be,
  input  logic [15:0]              req_wdata,
  output logic                     req_ack,
  output logic [15:0]              req_rdata,
  output logic [ADDR_W-1:0]        ext_addr,
  output logic [15:0]              ext_dout,
  output logic                     ext_dout_en,
  input  logic [15:0]              ext_din,
  output logic                     ext_rd_n,
  output logic                     ext_wrh_n,
  output logic                     ext_wrl_n,
  input  logic                     ext_wait_n,
  output logic [7:0]               ext_cs_n
);
  localparam int AREA_BITS = 3;
  localparam logic [ADDR_W-1:0] NARROW_MASK =
    {{(ADDR_W-NARROW_MAP_W){1'b0}}, {NARROW_MAP_W{1'b1}}};

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3, S_DONE} st_t;

  st_t                    state;
  logic [AREA_BITS-1:0]   area_q;
  logic [ADDR_W-1:1]      addr_q;
  logic                   wr_q;
  logic [1:0]             be_q;
  logic [15:0]            wdata_q;
  logic                   second_q;
  logic [WAIT_W-1:0]      wait_left;
  logic [15:0]            rdata_q;

  logic [AREA_BITS-1:0] area_sel;
  assign area_sel = wide_map ? req_waddr[ADDR_W-1 -: AREA_BITS]
                             : req_waddr[NARROW_MAP_W-1 -: AREA_BITS];

  logic bus16, slow, split, lo_byte, active, strobe, last, wait_more;
  assign bus16     = area_bus16[area_q];
  assign slow      = area_slow[area_q];
  assign split     = !bus16 && (be_q == 2'b11);
  assign lo_byte   = split ? second_q : (be_q == 2'b01);
  assign active    = (state == S_T1) || (state == S_T2) || (state == S_TW) || (state == S_T3);
  assign strobe    = (state == S_T2) || (state == S_TW) || (state == S_T3);
  assign last      = (state == S_T3) || ((state == S_T2) && !slow);
  assign wait_more = (wait_left != '0) || (area_pin_wait[area_q] && !ext_wait_n);

  logic [ADDR_W-1:0] full_a;
  assign full_a   = {addr_q, bus16 ? (be_q == 2'b01) : lo_byte};
  assign ext_addr = wide_map ? full_a : (full_a & NARROW_MASK);

  assign ext_cs_n    = active ? ~(8'b1 << area_q) : 8'hFF;
  assign ext_rd_n    = !(strobe && !wr_q);
  assign ext_wrh_n   = !(strobe && wr_q && (bus16 ? be_q[1] : 1'b1));
  assign ext_wrl_n   = !(strobe && wr_q && bus16 && be_q[0]);
  assign ext_dout_en = active && wr_q;
  assign ext_dout    = bus16 ? wdata_q
                             : {(lo_byte ? wdata_q[7:0] : wdata_q[15:8]), 8'h00};
  assign req_ack     = (state == S_DONE);
  assign req_rdata   = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      area_q    <= '0;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      be_q      <= 2'b00;
      wdata_q   <= '0;
      second_q  <= 1'b0;
      wait_left <= '0;
      rdata_q   <= '0;
    end else if (last) begin
      if (!wr_q) begin
        if (bus16)                 rdata_q       <= ext_din;
        else if (split && !second_q) rdata_q     <= {ext_din[15:8], 8'h00};
        else if (split)            rdata_q[7:0]  <= ext_din[15:8];
        else if (be_q == 2'b01)    rdata_q       <= {8'h00, ext_din[15:8]};
        else                       rdata_q       <= {ext_din[15:8], 8'h00};
      end
      if (split && !second_q) begin
        second_q <= 1'b1;
        state    <= S_T1;
      end else begin
        state <= S_DONE;
      end
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          area_q   <= area_sel;
          addr_q   <= req_waddr;
          wr_q     <= req_write;
          be_q     <= req_be;
          wdata_q  <= req_wdata;
          second_q <= 1'b0;
          state    <= S_T1;
        end
        S_T1: begin
          wait_left <= area_waits[area_q*WAIT_W +: WAIT_W];
          state     <= S_T2;
        end
        S_T2, S_TW: begin
          if (wait_more) begin
            if (wait_left != '0) wait_left <= wait_left - 1'b1;
            state <= S_TW;
          end else begin
            state <= S_T3;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/area_bus_ctrl_chk.sv
module area_bus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] area_bus16,
  input logic       req_ack,
  input logic       ext_rd_n,
  input logic       ext_wrh_n,
  input logic       ext_wrl_n,
  input logic [7:0] ext_cs_n
);
  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n));

  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wrh_n || !ext_wrl_n) |-> (ext_cs_n != 8'hFF));

  p_cs_no_hop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs_n != 8'hFF) |=> ((ext_cs_n == 8'hFF) || $stable(ext_cs_n)));

  p_narrow_low_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~ext_cs_n & ~area_bus16)) |-> ext_wrl_n);

  p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && (!ext_wrh_n || !ext_wrl_n)));

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  p_ack_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> ((ext_cs_n == 8'hFF) && ext_rd_n && ext_wrh_n && ext_wrl_n));
endmodule

bind area_bus_ctrl area_bus_ctrl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .area_bus16 (area_bus16),
  .req_ack    (req_ack),
  .ext_rd_n   (ext_rd_n),
  .ext_wrh_n  (ext_wrh_n),
  .ext_wrl_n  (ext_wrl_n),
  .ext_cs_n   (ext_cs_n)
);

// File: tb/area_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module area_bus_ctrl_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        wide_map;
  logic [7:0]  area_bus16, area_slow, area_pin_wait;
  logic [15:0] area_waits;
  logic        req_valid, req_write, req_ack;
  logic [23:1] req_waddr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata, req_rdata;
  logic [23:0] ext_addr;
  logic [15:0] ext_dout, ext_din;
  logic        ext_dout_en, ext_rd_n, ext_wrh_n, ext_wrl_n, ext_wait_n;
  logic [7:0]  ext_cs_n;

  assign ext_din = {ext_addr[7:0] ^ 8'h5A, ext_addr[7:0] ^ 8'hC3};

  area_bus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wide_map(wide_map), .area_bus16(area_bus16),
    .area_slow(area_slow), .area_waits(area_waits), .area_pin_wait(area_pin_wait),
    .req_valid(req_valid), .req_waddr(req_waddr), .req_write(req_write),
    .req_be(req_be), .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_dout_en(ext_dout_en),
    .ext_din(ext_din), .ext_rd_n(ext_rd_n), .ext_wrh_n(ext_wrh_n),
    .ext_wrl_n(ext_wrl_n), .ext_wait_n(ext_wait_n), .ext_cs_n(ext_cs_n)
  );

  int checks = 0;
  int errors = 0;

  int          ack_cyc, strobe_cyc, cs_cyc, nev;
  logic [7:0]  cs_seen, ack_cs;
  logic [15:0] rd;
  logic [23:0] ev_addr [2];
  logic [15:0] ev_dout [2];
  logic        ev_wrh [2];
  logic        ev_wrl [2];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic run(input logic [23:0] a, input logic wr, input logic [1:0] be,
                     input logic [15:0] wd, input int release_at);
    logic prev, s;
    @(negedge clk);
    req_valid  = 1'b1;
    req_waddr  = a[23:1];
    req_write  = wr;
    req_be     = be;
    req_wdata  = wd;
    ext_wait_n = (release_at > 0) ? 1'b0 : 1'b1;
    ack_cyc = 0; strobe_cyc = 0; cs_cyc = 0; nev = 0; cs_seen = 8'h00;
    ack_cs = 8'h00; rd = 16'h0; prev = 1'b0;
    for (int c = 1; c <= 200; c++) begin
      @(negedge clk);
      s = !ext_rd_n || !ext_wrh_n || !ext_wrl_n;
      if (s) begin
        strobe_cyc++;
        if (!prev) begin
          if (nev < 2) begin
            ev_addr[nev] = ext_addr;
            ev_dout[nev] = ext_dout;
            ev_wrh[nev]  = ext_wrh_n;
            ev_wrl[nev]  = ext_wrl_n;
          end
          nev++;
        end
      end
      prev = s;
      if (ext_cs_n != 8'hFF) begin
        cs_cyc++;
        cs_seen = cs_seen | ~ext_cs_n;
      end
      if (c == release_at) ext_wait_n = 1'b1;
      if (req_ack) begin
        ack_cyc = c;
        rd      = req_rdata;
        ack_cs  = ext_cs_n;
        break;
      end
    end
    req_valid  = 1'b0;
    ext_wait_n = 1'b1;
    chk("R10 ack cycle selects idle", ack_cs, 8'hFF);
  endtask

  task automatic t_reset();
    chk("R3 reset selects high", ext_cs_n, 8'hFF);
    chk("R3 reset strobes high", {ext_rd_n, ext_wrh_n, ext_wrl_n}, 3'b111);
    chk("R10 reset no ack", req_ack, 1'b0);
  endtask

  task automatic t_map_small();
    wide_map = 1'b0;
    run(24'hF21234, 1'b0, 2'b11, 16'h0, 0);
    chk("R1 small map select area1", cs_seen, 8'h02);
    chk("R1 small map address", ev_addr[0], 24'h021234);
    chk("R1 read data", rd, 16'h6EF7);
    wide_map = 1'b1;
  endtask

  task automatic t_map_wide();
    run(24'h3A0000, 1'b0, 2'b11, 16'h0, 0);
    chk("R2 wide map select area1", cs_seen, 8'h02);
    chk("R2 wide map address", ev_addr[0], 24'h3A0000);
    chk("R7 two-state ack cycle", ack_cyc, 3);
    chk("R7 two-state strobe length", strobe_cyc, 1);
    chk("R10 read data with ack", rd, 16'h5AC3);
  endtask

  task automatic t_wide_lanes();
    run(24'h200010, 1'b1, 2'b01, 16'hABCD, 0);
    chk("R6 lower byte odd address", ev_addr[0], 24'h200011);
    chk("R6 lower byte strobes", {ev_wrh[0], ev_wrl[0]}, 2'b10);
    chk("R6 lower byte data", ev_dout[0][7:0], 8'hCD);
    run(24'h200010, 1'b1, 2'b10, 16'hABCD, 0);
    chk("R6 upper byte even address", ev_addr[0], 24'h200010);
    chk("R6 upper byte strobes", {ev_wrh[0], ev_wrl[0]}, 2'b01);
    chk("R6 upper byte data", ev_dout[0][15:8], 8'hAB);
    run(24'h200010, 1'b1, 2'b11, 16'hABCD, 0);
    chk("R6 word one cycle", nev, 1);
    chk("R6 word strobes", {ev_wrh[0], ev_wrl[0]}, 2'b00);
  endtask

  task automatic t_narrow_byte();
    run(24'h400020, 1'b1, 2'b01, 16'h1234, 0);
    chk("R4 narrow odd address", ev_addr[0], 24'h400021);
    chk("R4 narrow lane strobes", {ev_wrh[0], ev_wrl[0]}, 2'b01);
    chk("R4 narrow data on upper lane", ev_dout[0][15:8], 8'h34);
    run(24'h400020, 1'b0, 2'b10, 16'h0, 0);
    chk("R4 narrow upper byte read", rd, 16'h7A00);
    run(24'h400020, 1'b0, 2'b01, 16'h0, 0);
    chk("R4 narrow lower byte read", rd, 16'h007B);
  endtask

  task automatic t_split_read();
    run(24'h400040, 1'b0, 2'b11, 16'h0, 0);
    chk("R5 two bus cycles", nev, 2);
    chk("R5 first half even", ev_addr[0], 24'h400040);
    chk("R5 second half odd", ev_addr[1], 24'h400041);
    chk("R5 assembled data", rd, 16'h1A1B);
    chk("R5 ack after second", ack_cyc, 5);
    chk("R3 select held across halves", cs_cyc, 4);
    chk("R3 select area2", cs_seen, 8'h04);
  endtask

  task automatic t_three_state();
    run(24'h600000, 1'b0, 2'b11, 16'h0, 20);
    chk("R8 ack with two waits", ack_cyc, 6);
    chk("R8 strobe with two waits", strobe_cyc, 4);
    chk("R9 disabled pin ignored", ack_cyc, 6);
  endtask

  task automatic t_pin_wait();
    run(24'h800000, 1'b0, 2'b11, 16'h0, 5);
    chk("R9 pin adds two waits ack", ack_cyc, 7);
    chk("R9 pin adds two waits strobe", strobe_cyc, 5);
    run(24'h800000, 1'b0, 2'b11, 16'h0, 0);
    chk("R9 pin high no extra ack", ack_cyc, 5);
    chk("R8 one wait strobe", strobe_cyc, 3);
  endtask

  task automatic t_two_state_ignores();
    run(24'h000100, 1'b0, 2'b11, 16'h0, 20);
    chk("R7 waits ignored ack", ack_cyc, 3);
    chk("R7 waits ignored strobe", strobe_cyc, 1);
  endtask

  task automatic t_split_three();
    run(24'hA00002, 1'b1, 2'b11, 16'hC0DE, 0);
    chk("R5 split slow ack", ack_cyc, 9);
    chk("R8 split slow strobe", strobe_cyc, 6);
    chk("R5 first addr", ev_addr[0], 24'hA00002);
    chk("R5 first byte upper", ev_dout[0][15:8], 8'hC0);
    chk("R5 second addr", ev_addr[1], 24'hA00003);
    chk("R5 second byte lower", ev_dout[1][15:8], 8'hDE);
    chk("R4 no low lane strobe", {ev_wrl[0], ev_wrl[1]}, 2'b11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wide_map = 1'b1;
    area_bus16 = 8'hDB; area_slow = 8'h38; area_waits = 16'h0583; area_pin_wait = 8'h11;
    req_valid = 1'b0; req_waddr = '0; req_write = 1'b0; req_be = 2'b11; req_wdata = '0;
    ext_wait_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map_small();
    t_map_wide();
    t_wide_lanes();
    t_narrow_byte();
    t_split_read();
    t_three_state();
    t_pin_wait();
    t_two_state_ignores();
    t_split_three();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule